// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt events from a set of on-chip peripheral sources and presents them to the CPU as one request line at a single interrupt level. For every source it keeps a pending bit, a mask bit and an in-service bit. When the CPU runs an interrupt-acknowledge cycle, the block returns an 8-bit vector that identifies the winning source, and it marks that source as in service.

Nesting is decided by the in-service bits. A request is raised only when the best unmasked pending source outranks every source that is still in service. Software controls how deep nesting may go by choosing when to clear in-service bits. Clearing the current source's bit early lets lower-priority sources interrupt that handler.

Sources come in two types. Edge-type sources capture a one-cycle event pulse, and the pending bit is cleared by hardware when the source is acknowledged. Level-type sources copy their input, which the peripheral holds high while any unmasked event remains. An acknowledge does not clear them.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the pending, mask and in-service registers and the vector base are all zero, and `irq_o` is low.
- R2: For an edge-type source (bit n of `LEVEL_MAP` is 0), a one-cycle pulse on its input sets pending bit n at the next clock edge. The bit stays set until that source is acknowledged. If a new pulse arrives in the acknowledge cycle itself, the bit stays set.
- R3: For a level-type source (bit n of `LEVEL_MAP` is 1), pending bit n equals the source input as sampled at the previous clock edge. An acknowledge does not clear it.
- R4: A pending source whose mask bit is 0 still reads as 1 in the pending register. It takes no part in the request or in the priority choice.
- R5: Sources are numbered 1 to `N_SRC`, and a lower number means a higher priority. When `irq_o` is high, `vec_o[7:5]` carries the 3-bit base and `vec_o[4:0]` carries the number of the lowest-numbered unmasked pending source.
- R6: `irq_o` is high only if that winning source number is smaller than the number of every source whose in-service bit is set.
- R7: When `ack_i` is high and a source is eligible, that source's in-service bit is set at the next clock edge. If it is an edge-type source, its pending bit is cleared at that edge.
- R8: When `ack_i` is high and no source is eligible, `vec_o[4:0]` is 0 (the error vector). No in-service bit becomes set.
- R9: A write to the in-service register (address 2) clears each bit written as 1. Bits written as 0 are unchanged, and software can never set an in-service bit. If an acknowledge sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: In the pending, mask and in-service registers, bit n stands for source n. Bit 0 and all bits above `N_SRC` read as zero, and writes to them have no effect.
- R11: Writes to the pending register (address 0) have no effect. The mask register is at address 1. Address 3 holds the vector base in bits [2:0], and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Source inputs; bit k is source k+1 (a pulse for edge-type sources, a level for level-type sources) |
| ack_i | input | 1 | Interrupt-acknowledge cycle strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector: {base[2:0], source number[4:0]} |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address: 0 pending, 1 mask, 2 in-service, 3 config |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on the address) |

## Verification
Directed sequences drive the nesting paths. A source is acknowledged, then a lower-priority source is held off while the first is in service. A higher-priority source is then let in, and the in-service bits are cleared one at a time. This shows whether the request is gated by the highest in-service source or by any in-service source at all. A fully masked acknowledge separates the error vector from a stale winner. Constrained random traffic mixes edge pulses, level toggling, acknowledges and register writes, which include write-zero and stray-bit writes. In that traffic, pulses that coincide with an acknowledge tell a set-wins merge apart from a clear-wins merge. Acknowledges that coincide with clears do the same for the in-service register. Level inputs held across an acknowledge tell the two source types apart.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 32;
  localparam int BASE_W = 3;
  localparam int NUM_W  = 5;
  localparam int VEC_W  = BASE_W + NUM_W;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_ISR  = 2'd2,
    REG_CFG  = 2'd3
  } irq_reg_e;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W = 8
) (
  input  logic [W-1:0]            req_i,
  output logic                    found_o,
  output logic [irq_pkg::NUM_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = irq_pkg::NUM_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int          N_SRC     = 8,
  parameter logic [31:0] LEVEL_MAP = 32'h0000_01E0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    if (LEVEL_MAP[k+1]) begin : g_level
      logic unused_clr;
      assign unused_clr = ack_clr_i[k];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[k] <= 1'b0;
        else         pend_q[k] <= src_i[k];
      end
      p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> pend_q[k] == $past(src_i[k]));
    end else begin : g_edge
      // new event wins over acknowledge clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[k] <= 1'b0;
        else         pend_q[k] <= src_i[k] | (pend_q[k] & ~ack_clr_i[k]);
      end
      p_edge_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[k] |=> pend_q[k]);
      p_edge_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[k] && !ack_clr_i[k]) |=> pend_q[k]);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
#(
  parameter int          N_SRC     = 8,
  parameter logic [31:0] LEVEL_MAP = 32'h0000_01E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam logic [DATA_W-1:0] VALID_BITS =
    ((DATA_W'(1) << (N_SRC + 1)) - DATA_W'(1)) & ~DATA_W'(1);

  logic [N_SRC-1:0]  pend, mask_q, isr_q, ack_set, sw_clr;
  logic [BASE_W-1:0] base_q;
  logic              win_found, isr_found, eligible;
  logic [NUM_W-1:0]  win_idx, isr_idx, src_num;
  logic              wr_mask, wr_isr, wr_cfg;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_mask = reg_we_i && (reg_addr_i == REG_MASK);
  assign wr_isr  = reg_we_i && (reg_addr_i == REG_ISR);
  assign wr_cfg  = reg_we_i && (reg_addr_i == REG_CFG);
  assign sw_clr  = wr_isr ? reg_wdata_i[N_SRC:1] : '0;

  irq_first_set #(.W(N_SRC)) u_win (
    .req_i(pend & mask_q), .found_o(win_found), .idx_o(win_idx)
  );
  irq_first_set #(.W(N_SRC)) u_top_isr (
    .req_i(isr_q), .found_o(isr_found), .idx_o(isr_idx)
  );

  // a winner must outrank the highest in-service source
  assign eligible = win_found && (!isr_found || (win_idx < isr_idx));
  assign src_num  = eligible ? (win_idx + NUM_W'(1)) : '0;
  assign irq_o    = eligible;
  assign vec_o    = {base_q, src_num};
  assign ack_set  = (ack_i && eligible) ? (N_SRC'(1) << win_idx) : '0;

  irq_pend_bank #(.N_SRC(N_SRC), .LEVEL_MAP(LEVEL_MAP)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .ack_clr_i(ack_set), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[N_SRC:1];
      if (wr_cfg)  base_q <= reg_wdata_i[BASE_W-1:0];
      isr_q <= (isr_q & ~sw_clr) | ack_set;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_PEND: reg_rdata_o = DATA_W'({pend, 1'b0});
      REG_MASK: reg_rdata_o = DATA_W'({mask_q, 1'b0});
      REG_ISR:  reg_rdata_o = DATA_W'({isr_q, 1'b0});
      default:  reg_rdata_o = DATA_W'(base_q);
    endcase
  end

  // checker-side decode of the vector
  logic [NUM_W-1:0]  chk_num;
  logic [N_SRC-1:0]  chk_onehot;
  logic [DATA_W-1:0] chk_above;
  assign chk_num    = vec_o[NUM_W-1:0];
  assign chk_onehot = (chk_num != '0) ? (N_SRC'(1) << (chk_num - NUM_W'(1))) : '0;
  assign chk_above  = (DATA_W'(1) << chk_num) - DATA_W'(1);

  p_irq_has_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chk_num != '0) && (chk_num <= NUM_W'(N_SRC)));
  p_nest_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (DATA_W'(isr_q) & chk_above) == '0);
  p_ack_sets_isr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && chk_num != '0) |=> (isr_q & $past(chk_onehot)) != '0);
  p_err_no_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && chk_num == '0) |=> (isr_q & ~$past(isr_q)) == '0);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_isr && !ack_i) |=> (isr_q & $past(reg_wdata_i[N_SRC:1])) == '0);
  p_no_sw_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (isr_q & ~$past(isr_q)) == '0);
  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != REG_CFG) |-> (reg_rdata_o & ~VALID_BITS) == '0);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
  localparam int          N     = 8;
  localparam logic [31:0] LEVEL = 32'h0000_01E0;
  localparam logic [31:0] VALID = 32'h0000_01FE;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] src = '0;
  logic        ack = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        irq;
  logic [7:0]  vec;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_pend = '0, m_mask = '0, m_isr = '0;
  logic [2:0]  m_base = '0;

  always #10 clk = ~clk;

  irq_nest_ctrl #(.N_SRC(N), .LEVEL_MAP(LEVEL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .ack_i(ack), .irq_o(irq),
    .vec_o(vec), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  function automatic int first_bit(logic [31:0] v);
    for (int n = 1; n <= N; n++) if (v[n]) return n;
    return 0;
  endfunction

  function automatic int exp_num();
    int w = first_bit(m_pend & m_mask);
    int t = first_bit(m_isr);
    if (w != 0 && (t == 0 || w < t)) return w;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_pend;
      2'd1: return m_mask;
      2'd2: return m_isr;
      default: return {29'b0, m_base};
    endcase
  endfunction

  task automatic cyc(logic [N-1:0] s, logic a, logic w, logic [1:0] ad, logic [31:0] d);
    int num;
    logic [31:0] set;
    @(negedge clk);
    src = s; ack = a; we = w; addr = ad; wdata = d;
    #1;
    num = exp_num();
    chk("R6 irq", 32'(irq), 32'(num != 0));
    chk("R5 R8 vec", 32'(vec), {24'b0, m_base, 5'(num)});
    case (ad)
      2'd0: chk("R2 R3 R4 R10 pend", rdata, exp_rd(ad));
      2'd1: chk("R4 R10 mask", rdata, exp_rd(ad));
      2'd2: chk("R7 R9 R10 isr", rdata, exp_rd(ad));
      default: chk("R11 cfg", rdata, exp_rd(ad));
    endcase
    @(posedge clk);
    set = (a && num != 0) ? (32'd1 << num) : 32'd0;
    if (w && ad == 2'd2) m_isr = m_isr & ~d;
    m_isr = (m_isr | set) & VALID;
    if (w && ad == 2'd1) m_mask = d & VALID;
    if (w && ad == 2'd3) m_base = d[2:0];
    for (int n = 1; n <= N; n++) begin
      if (LEVEL[n]) m_pend[n] = s[n-1];
      else          m_pend[n] = s[n-1] | (m_pend[n] & ~set[n]);
    end
  endtask

  task automatic show_all();
    for (int a = 0; a < 4; a++) cyc('0, 1'b0, 1'b0, 2'(a), '0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] lvl;
    logic [N-1:0] s;
    lvl = '0;
    // R1 reset state
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset reg", rdata, 32'h0);
      chk("R1 reset irq", 32'(irq), 32'h0);
      @(negedge clk);
    end
    rst_ni = 1'b1;
    show_all();

    // R8 error vector: pending but masked
    cyc(8'h01, 1'b0, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 1'b0, 2'd2, '0);
    show_all();
    // stray bits and pending writes ignored (R10, R11)
    cyc('0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    cyc('0, 1'b0, 1'b1, 2'd0, 32'h0);
    cyc('0, 1'b0, 1'b1, 2'd3, 32'hFFFF_FFFD);
    show_all();

    // nesting: source 3, then 4 blocked, 2 allowed
    cyc(8'h04, 1'b0, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 1'b0, 2'd2, '0);
    cyc(8'h08, 1'b0, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 1'b0, 2'd2, '0);
    cyc(8'h02, 1'b0, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 1'b0, 2'd2, '0);
    cyc('0, 1'b0, 1'b1, 2'd2, 32'h0);          // write zero: no effect
    cyc('0, 1'b0, 1'b1, 2'd2, 32'h0000_0008);  // clear source 3 early
    cyc('0, 1'b0, 1'b0, 2'd2, '0);
    cyc('0, 1'b0, 1'b1, 2'd2, 32'h0000_0004);  // clear source 2
    cyc('0, 1'b1, 1'b0, 2'd2, '0);             // source 4 now granted
    // ack and clear same bit together, event during ack
    cyc(8'h01, 1'b0, 1'b0, 2'd0, '0);
    cyc(8'h01, 1'b1, 1'b1, 2'd2, 32'h0000_0002);
    show_all();
    // level source survives ack
    cyc(8'h10, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    cyc(8'h10, 1'b1, 1'b0, 2'd0, '0);
    cyc(8'h10, 1'b0, 1'b0, 2'd0, '0);
    cyc('0, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    show_all();

    // random traffic
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic w = (r < 18);
      logic [1:0] ad = 2'($urandom_range(0, 3));
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 7) == 0) lvl[4 + $urandom_range(0, 3)] ^= 1'b1;
      s = 8'($urandom()) & 8'($urandom()) & 8'($urandom()) & 8'h0F;
      s = s | (lvl & 8'hF0);
      if (ad == 2'd2 && w && $urandom_range(0, 1) == 0) d = d & 32'h0000_00AA;
      cyc(s, ($urandom_range(0, 3) == 0), w, ad, d);
    end
    show_all();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule